// File: doc/BRIEF.md
# Camera parallel capture controller

This block takes pixels from a parallel camera bus of up to 14 data pins. A vertical sync input marks the frames, a horizontal sync input qualifies the active part of each line, and a pixel clock gives the sampling edges. The pixel clock, both syncs and the pins are assumed to be already synchronous to the system clock. The block finds the pixel clock edge itself with an edge detector.

Software arms the block by writing a capture request bit. Capture never starts in the middle of a frame. It starts at the next frame start. In single-frame mode exactly one frame is taken and the request bit then clears itself. In continuous mode every frame is taken for as long as the bit stays set. A request to stop that arrives inside a frame is held back until that frame is over. On each sampled beat the block pulls the data field out of the pin bus, using the configured data width, spare pin pairs and alignment. It presents the field zero-extended, with a one-cycle valid strobe. It also pulses a flag when each captured frame ends.

Top module: `cam_capture`

## Requirements
- R1: While rst_ni is low and right after reset, cap_o, active_o, pix_valid_o and frame_end_o are 0.
- R2: Writing 1 to the request (cap_wr_i=1, cap_wdata_i=1) sets cap_o, but no word is captured until the next inactive-to-active transition of vertical sync, so the rest of a frame already in progress is skipped. Writing 0 while armed and not yet running clears cap_o at once, and the next frame is not captured.
- R3: With cfg_single_i=1, exactly one frame is captured. At its end frame_end_o pulses and, in the same cycle, cap_o and active_o drop to 0.
- R4: With cfg_single_i=0, every frame is captured while cap_o stays 1, and frame_end_o pulses once per frame.
- R5: In continuous mode, writing 0 while vertical sync is active leaves cap_o reading 1. Words keep being captured until the end of that frame, and then cap_o and active_o drop to 0. Writing 0 during vertical blanking stops capture at once.
- R6: cfg_width_i selects the data width: code 0, 1, 2 and 3 give 8, 10, 12 and 14 bits.
- R7: cfg_spare_i gives the number of unused pin pairs (0 to 2). With cfg_align_hi_i=1 the field starts at pin 2*cfg_spare_i. With cfg_align_hi_i=0 it starts at pin 0.
- R8: cfg_vs_pol_i gives the active level of vertical sync. A frame spans the time that vsync_i equals that level.
- R9: A word is sampled only on the pixel clock edge chosen by cfg_pclk_fall_i (0 = rising, 1 = falling), and only while hsync_i equals cfg_hs_pol_i. Exactly one word is taken per pixel clock period.
- R10: frame_end_o is high for exactly one cycle per captured frame.
- R11: While active_o is 1, changes on the configuration inputs have no effect. The values present when capture started stay in use.
- R12: pix_o is the extracted field zero-extended to 14 bits, and pix_valid_o is a one-cycle strobe one clock after the sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pclk_i | input | 1 | Camera pixel clock, synchronous level |
| vsync_i | input | 1 | Vertical sync |
| hsync_i | input | 1 | Horizontal sync |
| pins_i | input | PIN_W | Camera data pins |
| cap_wr_i | input | 1 | Write strobe for the capture request bit |
| cap_wdata_i | input | 1 | Value written to the capture request bit |
| cfg_single_i | input | 1 | 1 = single frame, 0 = continuous |
| cfg_vs_pol_i | input | 1 | Active level of vertical sync |
| cfg_hs_pol_i | input | 1 | Active level of horizontal sync |
| cfg_pclk_fall_i | input | 1 | Sampling edge: 0 rising, 1 falling |
| cfg_width_i | input | 2 | Data width code |
| cfg_spare_i | input | 2 | Unused pin pairs |
| cfg_align_hi_i | input | 1 | Field on high pins when 1 |
| cap_o | output | 1 | Capture request bit read back |
| active_o | output | 1 | Capture run in progress |
| pix_o | output | PIN_W | Captured word, zero-extended |
| pix_valid_o | output | 1 | Strobe for pix_o |
| frame_end_o | output | 1 | End of a captured frame |

## Verification
The bench sweeps every legal mix of width, spare pairs and alignment in single-frame mode. It compares each word with a shifted and masked copy of the driven pins. A wrong shift or mask shows up as a wrong word, and upper bits left set break the zero extension. The bench arms the block in the middle of a frame. A design that starts sampling at once would deliver the tail of that frame. The bench also clears the request mid-frame in continuous mode. A design that honours the clear at once would drop the rest of the frame or report cap_o as 0 too early. Further cases cover active-low vertical sync, the falling sample edge with gating by an active-low horizontal sync, and configuration writes during a run. A missing shadow would switch the width in the middle of a frame.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int WCODE_W = 2;
  localparam int SPARE_W = 2;
  localparam int BASE_BITS = 8;

  typedef struct packed {
    logic               single;
    logic               vs_pol;
    logic               hs_pol;
    logic               pclk_fall;
    logic [WCODE_W-1:0] width;
    logic [SPARE_W-1:0] spare;
    logic               align_hi;
  } cam_cfg_t;
endpackage

// File: rtl/cam_edge.sv
module cam_edge #(
  parameter logic RST_LVL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= RST_LVL;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
  assign fall_o = ~sig_i & sig_q;
endmodule

// File: rtl/cam_extract.sv
module cam_extract import cam_pkg::*; #(
  parameter int PIN_W = 14
) (
  input  logic [PIN_W-1:0]   pins_i,
  input  logic [WCODE_W-1:0] width_i,
  input  logic [SPARE_W-1:0] spare_i,
  input  logic               align_hi_i,
  output logic [PIN_W-1:0]   word_o
);
  localparam int SH_W = SPARE_W + 1;

  logic [SH_W-1:0]  shift;
  logic [PIN_W-1:0] shifted;
  logic [4:0]       nbits;

  always_comb begin
    shift   = align_hi_i ? {spare_i, 1'b0} : '0;
    shifted = pins_i >> shift;
    nbits   = 5'(BASE_BITS) + {2'b00, width_i, 1'b0};
  end

  for (genvar i = 0; i < PIN_W; i++) begin : g_bit
    assign word_o[i] = shifted[i] & (5'(i) < nbits);
  end
endmodule

// File: rtl/cam_ctrl.sv
module cam_ctrl import cam_pkg::*; (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  cam_cfg_t cfg_i,
  input  logic     vs_rise_i,
  input  logic     vs_fall_i,
  input  logic     vs_act_i,
  input  logic     cap_wr_i,
  input  logic     cap_wdata_i,
  output cam_cfg_t cfg_o,
  output logic     cap_o,
  output logic     run_o,
  output logic     frame_end_o
);
  logic cap_q, run_q, pend_q, fe_q;
  logic cap_n, run_n, pend_n, fe_n;
  cam_cfg_t cfg_q;

  always_comb begin
    cap_n  = cap_q;
    run_n  = run_q;
    pend_n = pend_q;
    fe_n   = 1'b0;
    if (!run_q && cap_q && vs_rise_i) run_n = 1'b1;
    if (run_q && vs_fall_i) begin
      fe_n = 1'b1;
      if (cfg_q.single || pend_q) begin
        run_n  = 1'b0;
        cap_n  = 1'b0;
        pend_n = 1'b0;
      end
    end
    if (cap_wr_i) begin
      if (cap_wdata_i) begin
        cap_n  = 1'b1;
        pend_n = 1'b0;
      end else if (run_n && vs_act_i) begin
        pend_n = 1'b1;  // stop deferred to frame end
      end else begin
        cap_n  = 1'b0;
        run_n  = 1'b0;
        pend_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= 1'b0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      fe_q   <= 1'b0;
      cfg_q  <= '0;
    end else begin
      cap_q  <= cap_n;
      run_q  <= run_n;
      pend_q <= pend_n;
      fe_q   <= fe_n;
      if (!run_q) cfg_q <= cfg_i;  // shadow frozen during a run
    end
  end

  assign cfg_o       = cfg_q;
  assign cap_o       = cap_q;
  assign run_o       = run_q;
  assign frame_end_o = fe_q;
endmodule

// File: rtl/cam_capture.sv
module cam_capture import cam_pkg::*; #(
  parameter int PIN_W = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pclk_i,
  input  logic               vsync_i,
  input  logic               hsync_i,
  input  logic [PIN_W-1:0]   pins_i,
  input  logic               cap_wr_i,
  input  logic               cap_wdata_i,
  input  logic               cfg_single_i,
  input  logic               cfg_vs_pol_i,
  input  logic               cfg_hs_pol_i,
  input  logic               cfg_pclk_fall_i,
  input  logic [WCODE_W-1:0] cfg_width_i,
  input  logic [SPARE_W-1:0] cfg_spare_i,
  input  logic               cfg_align_hi_i,
  output logic               cap_o,
  output logic               active_o,
  output logic [PIN_W-1:0]   pix_o,
  output logic               pix_valid_o,
  output logic               frame_end_o
);
  cam_cfg_t cfg_in, cfg_q;
  logic vs_act, hs_act, vs_rise, vs_fall, pc_rise, pc_fall;
  logic run, smp;
  logic [PIN_W-1:0] word, pix_q;
  logic valid_q;

  assign cfg_in = '{single: cfg_single_i, vs_pol: cfg_vs_pol_i,
                    hs_pol: cfg_hs_pol_i, pclk_fall: cfg_pclk_fall_i,
                    width: cfg_width_i, spare: cfg_spare_i,
                    align_hi: cfg_align_hi_i};

  assign vs_act = (vsync_i == cfg_q.vs_pol);
  assign hs_act = (hsync_i == cfg_q.hs_pol);

  cam_edge #(.RST_LVL(1'b1)) u_vs_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(vs_act),
    .rise_o(vs_rise), .fall_o(vs_fall)
  );

  cam_edge #(.RST_LVL(1'b0)) u_pc_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(pclk_i),
    .rise_o(pc_rise), .fall_o(pc_fall)
  );

  cam_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_i(cfg_in),
    .vs_rise_i(vs_rise), .vs_fall_i(vs_fall), .vs_act_i(vs_act),
    .cap_wr_i(cap_wr_i), .cap_wdata_i(cap_wdata_i),
    .cfg_o(cfg_q), .cap_o(cap_o), .run_o(run), .frame_end_o(frame_end_o)
  );

  cam_extract #(.PIN_W(PIN_W)) u_extract (
    .pins_i(pins_i), .width_i(cfg_q.width), .spare_i(cfg_q.spare),
    .align_hi_i(cfg_q.align_hi), .word_o(word)
  );

  assign smp = run & vs_act & hs_act & (cfg_q.pclk_fall ? pc_fall : pc_rise);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= smp;
      if (smp) pix_q <= word;
    end
  end

  assign active_o    = run;
  assign pix_o       = pix_q;
  assign pix_valid_o = valid_q;
endmodule

// File: rtl/cam_capture_chk.sv
module cam_capture_chk import cam_pkg::*; #(
  parameter int PIN_W = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cap_o,
  input logic             active_o,
  input logic             frame_end_o,
  input logic             pix_valid_o,
  input logic [PIN_W-1:0] pix_o,
  input cam_cfg_t         cfg_q,
  input logic             vs_act
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (!cap_o && !active_o && !pix_valid_o && !frame_end_o);
    end
  end

  a_r2_valid_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> $past(active_o));

  a_r3_single_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_o && cfg_q.single) |-> (!active_o && !cap_o));

  a_r5_stop_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cap_o) && $past(active_o)) |-> (frame_end_o || $past(!vs_act)));

  a_r10_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |=> !frame_end_o);

  a_r11_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && $past(active_o)) |-> $stable(cfg_q));

  a_r12_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> ((pix_o >> (BASE_BITS + 2 * cfg_q.width)) == '0));
endmodule

bind cam_capture cam_capture_chk #(.PIN_W(PIN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cap_o(cap_o), .active_o(active_o),
  .frame_end_o(frame_end_o), .pix_valid_o(pix_valid_o), .pix_o(pix_o),
  .cfg_q(cfg_q), .vs_act(vs_act)
);

// File: tb/sim_cam_capture.sv
module sim_cam_capture;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pclk = 0, vsync = 0, hsync = 0;
  logic [13:0] pins = '0;
  logic cap_wr = 0, cap_wdata = 0;
  logic c_single = 1, c_vpol = 1, c_hpol = 1, c_fall = 0, c_align = 0;
  logic [1:0] c_width = 0, c_spare = 0;
  logic cap_o, active_o, pix_valid_o, frame_end_o;
  logic [13:0] pix_o;

  int errors = 0, checks = 0, fe_cnt = 0;
  logic [13:0] got_q[$];
  logic [13:0] exp_q[$];
  int ew = 0, es = 0, ea = 0;

  always #10 clk = ~clk;

  cam_capture u0 (
    .clk_i(clk), .rst_ni(rst_n), .pclk_i(pclk), .vsync_i(vsync), .hsync_i(hsync),
    .pins_i(pins), .cap_wr_i(cap_wr), .cap_wdata_i(cap_wdata),
    .cfg_single_i(c_single), .cfg_vs_pol_i(c_vpol), .cfg_hs_pol_i(c_hpol),
    .cfg_pclk_fall_i(c_fall), .cfg_width_i(c_width), .cfg_spare_i(c_spare),
    .cfg_align_hi_i(c_align), .cap_o(cap_o), .active_o(active_o), .pix_o(pix_o),
    .pix_valid_o(pix_valid_o), .frame_end_o(frame_end_o)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (pix_valid_o) got_q.push_back(pix_o);
      if (frame_end_o) fe_cnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cap(input logic v);
    cap_wr = 1; cap_wdata = v;
    wait_n(1);
    cap_wr = 0;
  endtask

  task automatic vs_set(input bit act);
    vsync = act ? c_vpol : ~c_vpol;
  endtask

  function automatic logic [13:0] field(input logic [13:0] d, input int w, input int s, input int a);
    logic [13:0] m;
    m = 14'((32'd1 << (8 + 2 * w)) - 1);
    return (d >> (a ? 2 * s : 0)) & m;
  endfunction

  task automatic pixel(input logic [13:0] d, input bit hs, input bit expect_it);
    hsync = hs ? c_hpol : ~c_hpol;
    pins = d;
    wait_n(1);
    pclk = 1; wait_n(2);
    pclk = 0; wait_n(2);
    hsync = ~c_hpol;
    if (expect_it) exp_q.push_back(field(d, ew, es, ea));
  endtask

  task automatic frame(input int n, input int seed, input bit expect_it);
    vs_set(1); wait_n(3);
    for (int i = 0; i < n; i++)
      pixel(14'((seed * 37 + i * 32'h1357 + 5) & 32'h3fff), 1, expect_it);
    wait_n(2);
    vs_set(0); wait_n(4);
  endtask

  task automatic compare(input string tag);
    chk(got_q.size() == exp_q.size(), {tag, " count"}, got_q.size(), exp_q.size());
    if (got_q.size() == exp_q.size())
      foreach (exp_q[i]) chk(got_q[i] === exp_q[i], tag, got_q[i], exp_q[i]);
    got_q.delete(); exp_q.delete();
  endtask

  task automatic set_cfg(input int w, input int s, input int a);
    c_width = 2'(w); c_spare = 2'(s); c_align = 1'(a);
    ew = w; es = s; ea = a;
    wait_n(2);
  endtask

  initial begin
    int fe0;
    hsync = ~c_hpol; vsync = ~c_vpol;
    wait_n(3);
    chk(!cap_o && !active_o && !pix_valid_o && !frame_end_o, "R1 reset", cap_o, 0);
    rst_n = 1;
    wait_n(2);
    chk(!cap_o && !active_o, "R1 after reset", active_o, 0);

    // R6 R7 R12 R3: width/spare/alignment sweep in single-frame mode
    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 3; s++)
        for (int a = 0; a < 2; a++) begin
          if (8 + 2 * w + 2 * s <= 14) begin
            set_cfg(w, s, a);
            fe0 = fe_cnt;
            write_cap(1);
            wait_n(3);
            chk(cap_o && !active_o && got_q.size() == 0, "R2 armed idle", active_o, 0);
            frame(3, w * 8 + s * 2 + a, 1);
            compare("R6 R7 R12 field");
            chk(!cap_o && !active_o, "R3 single clears", cap_o, 0);
            chk(fe_cnt - fe0 == 1, "R10 one pulse", fe_cnt - fe0, 1);
            frame(2, 99, 0);
            compare("R3 no second frame");
          end
        end

    // R2: armed mid-frame waits for next start
    set_cfg(1, 1, 1);
    vs_set(1); wait_n(3);
    write_cap(1);
    pixel(14'h2aa5, 1, 0); pixel(14'h1234, 1, 0);
    vs_set(0); wait_n(4);
    compare("R2 mid-frame skip");
    frame(2, 7, 1);
    compare("R2 next frame");

    // R2: clear while armed disarms
    write_cap(1); wait_n(2);
    write_cap(0); wait_n(1);
    chk(!cap_o, "R2 clear armed", cap_o, 0);
    frame(2, 8, 0);
    compare("R2 disarmed");

    // R4: continuous
    c_single = 0; set_cfg(2, 0, 0);
    fe0 = fe_cnt;
    write_cap(1);
    frame(2, 11, 1); frame(3, 12, 1); frame(2, 13, 1);
    compare("R4 continuous");
    chk(fe_cnt - fe0 == 3, "R4 frame ends", fe_cnt - fe0, 3);
    chk(cap_o && active_o, "R4 still running", cap_o, 1);

    // R5: clear mid-frame finishes the frame
    fe0 = fe_cnt;
    vs_set(1); wait_n(3);
    pixel(14'h0f0f, 1, 1);
    write_cap(0); wait_n(1);
    chk(cap_o && active_o, "R5 reads set", cap_o, 1);
    pixel(14'h3c3c, 1, 1); pixel(14'h0123, 1, 1);
    vs_set(0); wait_n(4);
    compare("R5 finish frame");
    chk(!cap_o && !active_o, "R5 stopped", cap_o, 0);
    chk(fe_cnt - fe0 == 1, "R5 frame end", fe_cnt - fe0, 1);
    frame(2, 14, 0);
    compare("R5 no more");

    // R5: clear in blanking stops at once
    write_cap(1); frame(1, 15, 1);
    write_cap(0); wait_n(1);
    chk(!cap_o && !active_o, "R5 blank stop", cap_o, 0);
    frame(1, 16, 0);
    compare("R5 blank");

    // R8: active-low vertical sync
    c_single = 1; c_vpol = 0; vsync = 1; set_cfg(0, 0, 0);
    write_cap(1);
    vsync = 1; pixel(14'h00ff, 1, 0);
    frame(3, 20, 1);
    compare("R8 low polarity");
    chk(!cap_o, "R8 single done", cap_o, 0);

    // R9: falling edge, active-low hsync, gating
    c_fall = 1; c_hpol = 0; hsync = 1; set_cfg(3, 0, 0);
    write_cap(1); wait_n(2);
    vs_set(1); wait_n(3);
    pixel(14'h3fff, 1, 1); pixel(14'h1111, 0, 0);
    pixel(14'h2a2a, 1, 1); pixel(14'h0555, 0, 0);
    vs_set(0); wait_n(4);
    compare("R9 edge and gating");

    // R11: config change mid-run ignored
    c_fall = 0; c_hpol = 1; hsync = 0; c_single = 0; set_cfg(0, 0, 0);
    write_cap(1);
    vs_set(1); wait_n(3);
    pixel(14'h3abc, 1, 1);
    c_width = 3; c_align = 1; c_spare = 2; c_single = 1;
    wait_n(2);
    pixel(14'h3def, 1, 1);
    vs_set(0); wait_n(4);
    chk(cap_o, "R11 mode kept", cap_o, 1);
    frame(2, 30, 1);
    write_cap(0); wait_n(3);
    compare("R11 frozen cfg");
    ew = 3; es = 2; ea = 1;
    write_cap(1);
    frame(2, 31, 1);
    compare("R11 new cfg applies");
    chk(!cap_o, "R11 single now", cap_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule